// File: doc/BRIEF.md
# Asynchronous Serial Port with Hardware Handshake

A full-duplex asynchronous serial port for a system clock of about 20 MHz. A programmable divisor sets a 16x oversampling tick, so one bit lasts sixteen ticks. Frames carry 7 or 8 data bits, least significant bit first, with optional odd or even parity and one stop bit. Software writes the transmit byte, the divisor and the mode through a small write port. It takes received bytes from a read port that is popped by a strobe. Error and status flags sit beside the read data.

The receiver samples the line through a two-stage synchroniser. It confirms a start bit half a bit after the falling edge and then samples each later bit at its centre. It reports parity, framing and overrun errors, and it recognises a line held low for a whole frame as a break. When handshaking is enabled, the transmitter looks at the clear-to-send input only at the moment a frame would begin. The request-to-send output is asserted while a byte waits in the transmit holding register. A divisor of zero freezes both directions.

Top module: `uart_fc`

## Requirements
- R1: A nonzero divisor D gives a bit period of exactly 16*D clock cycles on `txd`. D = 1 is the fastest rate, at 16 clocks per bit.
- R2: While the divisor is 0, no frame is sent and none is received. The divisor resets to 0.
- R3: A frame is a start bit (0), then the data bits LSB first, then the parity bit if enabled, then one stop bit (1). The mode register is written with `wr_sel`=2, using these bits: bit 0 set selects 8 data bits and clear selects 7; bits 2:1 select parity, with 01 for odd, 10 for even, and 00 or 11 for none; bit 3 enables the handshake. The mode resets to 8 bits, no parity, no handshake.
- R4: The even parity bit makes the count of ones over the data bits and the parity bit even. The odd parity bit makes that count odd.
- R5: A write to the transmit register (`wr_sel`=0) while it already holds an unsent byte is ignored. The divisor is written with `wr_sel`=1.
- R6: With the handshake enabled, a frame starts only if `cts_n` is low. While `cts_n` is high, the byte stays in the holding register.
- R7: A change of `cts_n` after a frame has started does not alter or stop that frame.
- R8: `rts_n` is low exactly while the handshake is enabled and the holding register holds an unsent byte. It is high otherwise.
- R9: A received frame sets `rx_valid` and presents the byte on `rd_data`. A 7-bit byte has bit 7 = 0. A received parity bit that does not match raises `err_parity`. A `rd_en` pulse clears `rx_valid` and all error flags.
- R10: A stop bit sampled low raises `err_frame` and keeps the received data.
- R11: A line held low for the whole frame gives `rd_data` = 0 with `rx_break` and `err_frame` set. No further frame is reported until the line returns high.
- R12: A frame that completes while the previous byte is unread sets `err_overrun`, discards the new byte and keeps the old one. If `rd_en` falls in the completion cycle, the new byte is stored and no overrun is flagged.
- R13: The receiver decodes 8-bit frames correctly at bit rates 3.0% fast and 2.5% slow.
- R14: After reset, `txd` and `rts_n` are high, `tx_empty` is 1, and `tx_busy`, `rx_valid` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 transmit byte, 1 divisor, 2 mode |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Pops the received byte and clears the flags |
| rd_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Unread received byte present |
| err_parity | output | 1 | Parity mismatch on the held byte |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | A frame was lost because the byte was unread |
| rx_break | output | 1 | Break received |
| tx_empty | output | 1 | Transmit holding register free |
| tx_busy | output | 1 | A frame is being shifted out |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The read strobe and the completion of a new frame can fall in the same clock cycle while an older byte is still unread. In that cycle the pop must win against the overrun rule. The bench sets the divisor to 1, so the tick is steady and the completion edge can be counted from the start edge. It leaves one byte unread, sends a second frame, and pulses `rd_en` for exactly the counted completion cycle. It then expects `rx_valid` set, the second byte on `rd_data` and `err_overrun` clear. A separate run that leaves the byte unread shows the opposite outcome, where the first byte is kept and the overrun flag is raised.

// File: rtl/uart_fc.sv
module uart_fc #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rx_valid,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun,
  output logic             rx_break,
  output logic             tx_empty,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  input  logic             cts_n,
  output logic             rts_n
);
  localparam logic [1:0] SEL_TX = 2'd0, SEL_DIV = 2'd1, SEL_MODE = 2'd2;
  localparam int OSR = 16;
  localparam int PW  = $clog2(OSR);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(OSR / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAIT} rx_st_t;

  function automatic logic calc_par(input logic [7:0] d, input logic len8, input logic odd);
    logic x;
    x = len8 ? ^d : ^d[6:0];
    return odd ? ~x : x;
  endfunction

  logic [DIV_W-1:0] div_q, tick_cnt;
  logic             mode_len8, mode_flow;
  logic [1:0]       mode_par;
  logic             tick, par_en, par_odd;
  logic [1:0]       rx_sync, cts_sync;
  logic             rx_s, cts_ok;

  assign tick    = (div_q != '0) && (tick_cnt >= div_q - 1'b1);
  assign par_en  = (mode_par == 2'b01) || (mode_par == 2'b10);
  assign par_odd = (mode_par == 2'b01);
  assign rx_s    = rx_sync[1];
  assign cts_ok  = !cts_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      mode_len8 <= 1'b1;
      mode_par  <= 2'b00;
      mode_flow <= 1'b0;
      tick_cnt  <= '0;
      rx_sync   <= 2'b11;
      cts_sync  <= 2'b11;
    end else begin
      rx_sync  <= {rx_sync[0], rxd};
      cts_sync <= {cts_sync[0], cts_n};
      if (div_q == '0 || tick) tick_cnt <= '0;
      else                     tick_cnt <= tick_cnt + 1'b1;
      if (wr_en && wr_sel == SEL_DIV) div_q <= wr_data;
      if (wr_en && wr_sel == SEL_MODE) begin
        mode_len8 <= wr_data[0];
        mode_par  <= wr_data[2:1];
        mode_flow <= wr_data[3];
      end
    end
  end

  // Transmitter
  logic [7:0]  thr;
  logic        thr_full, tx_busy_q, tx_go;
  logic [10:0] tx_sh, tx_frame;
  logic [3:0]  tx_left, tx_nbits;
  logic [PW-1:0] tx_ph;

  assign tx_go    = tick && !tx_busy_q && thr_full && (!mode_flow || cts_ok);
  assign tx_nbits = 4'd2 + (mode_len8 ? 4'd8 : 4'd7) + {3'b0, par_en};

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    if (mode_len8) begin
      tx_frame[8:1] = thr;
      if (par_en) tx_frame[9] = calc_par(thr, 1'b1, par_odd);
    end else begin
      tx_frame[7:1] = thr[6:0];
      if (par_en) tx_frame[8] = calc_par(thr, 1'b0, par_odd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr       <= '0;
      thr_full  <= 1'b0;
      tx_busy_q <= 1'b0;
      tx_sh     <= '1;
      tx_left   <= '0;
      tx_ph     <= '0;
    end else begin
      if (tx_go) begin
        tx_sh     <= tx_frame;
        tx_busy_q <= 1'b1;
        tx_left   <= tx_nbits;
        tx_ph     <= '0;
        thr_full  <= 1'b0;
      end else if (tx_busy_q && tick) begin
        if (tx_ph == PH_LAST) begin
          tx_ph   <= '0;
          tx_sh   <= {1'b1, tx_sh[10:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_busy_q <= 1'b0;
        end else begin
          tx_ph <= tx_ph + 1'b1;
        end
      end
      if (wr_en && wr_sel == SEL_TX && !thr_full) begin
        thr      <= wr_data[7:0];
        thr_full <= 1'b1;
      end
    end
  end

  assign txd      = tx_busy_q ? tx_sh[0] : 1'b1;
  assign tx_busy  = tx_busy_q;
  assign tx_empty = !thr_full;
  assign rts_n    = !(mode_flow && thr_full);

  // Receiver
  rx_st_t      rx_st;
  logic [PW-1:0] rx_ph;
  logic [3:0]  rx_idx, rx_last;
  logic [9:0]  rx_sh;
  logic        rx_any1, rx_done;
  logic [7:0]  rx_byte, rx_data;
  logic        rx_pbit, rx_perr, rx_brk;

  assign rx_last = (mode_len8 ? 4'd8 : 4'd7) + {3'b0, par_en};
  assign rx_done = tick && rx_st == RX_BITS && rx_ph == PH_LAST && rx_idx == rx_last;
  assign rx_byte = mode_len8 ? rx_sh[7:0] : {1'b0, rx_sh[6:0]};
  assign rx_pbit = mode_len8 ? rx_sh[8] : rx_sh[7];
  assign rx_perr = par_en && (rx_pbit != calc_par(rx_byte, mode_len8, par_odd));
  assign rx_brk  = !rx_any1 && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st   <= RX_IDLE;
      rx_ph   <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_any1 <= 1'b0;
    end else if (tick) begin
      case (rx_st)
        RX_IDLE: if (!rx_s) begin
          rx_st <= RX_START;
          rx_ph <= '0;
        end
        RX_START: if (rx_ph == PH_MID) begin
          rx_st   <= rx_s ? RX_IDLE : RX_BITS;
          rx_ph   <= '0;
          rx_idx  <= '0;
          rx_any1 <= 1'b0;
        end else begin
          rx_ph <= rx_ph + 1'b1;
        end
        RX_BITS: if (rx_ph == PH_LAST) begin
          rx_ph         <= '0;
          rx_sh[rx_idx] <= rx_s;
          rx_any1       <= rx_any1 | rx_s;
          rx_idx        <= rx_idx + 1'b1;
          if (rx_idx == rx_last) rx_st <= rx_s ? RX_IDLE : RX_WAIT;
        end else begin
          rx_ph <= rx_ph + 1'b1;
        end
        default: if (rx_s) rx_st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      rx_break    <= 1'b0;
    end else begin
      if (rd_en) begin
        rx_valid    <= 1'b0;
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
        rx_break    <= 1'b0;
      end
      if (rx_done) begin
        if (rx_valid && !rd_en) begin
          err_overrun <= 1'b1;
        end else begin
          rx_valid   <= 1'b1;
          rx_data    <= rx_brk ? 8'h00 : rx_byte;
          err_parity <= rx_perr;
          err_frame  <= !rx_s;
          rx_break   <= rx_brk;
        end
      end
    end
  end

  assign rd_data = rx_data;

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> ($stable(rx_st) && $stable(tx_left) && $stable(tx_busy_q)))
    else $error("divisor zero but port advanced");

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy_q) |-> (!$past(mode_flow) || $past(cts_ok)))
    else $error("frame started without clear-to-send");

  p_mid_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy_q && tx_left != 4'd1) |-> tx_busy_q)
    else $error("frame cut short");

  p_ovr_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $stable(rx_data))
    else $error("overrun replaced held byte");

  p_break_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |-> (rx_data == 8'h00 && err_frame))
    else $error("break without zero data and framing error");
endmodule

// File: tb/uart_fc_bench.sv
module uart_fc_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, loop = 1'b0, rxd_b = 1'b1, cts_n = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rx_valid, err_parity, err_frame, err_overrun, rx_break, tx_empty, tx_busy;
  logic txd, rxd, rts_n;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  assign rxd = loop ? txd : rxd_b;

  uart_fc u_uart_fc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .rx_break(rx_break),
    .tx_empty(tx_empty), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
    .cts_n(cts_n), .rts_n(rts_n));

  // {mode[3:0], data[7:0], expected parity bit}
  localparam logic [12:0] VEC [0:7] = '{
    {4'b0001, 8'hA5, 1'b0}, {4'b0101, 8'hA5, 1'b0},
    {4'b0011, 8'hA5, 1'b1}, {4'b0100, 8'h53, 1'b0},
    {4'b0010, 8'h7F, 1'b0}, {4'b0101, 8'h01, 1'b1},
    {4'b0000, 8'h2C, 1'b0}, {4'b0011, 8'h00, 1'b1}};

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rx_send(input logic [10:0] bits, input int n, input int p);
    for (int i = 0; i < n; i++) begin
      rxd_b = bits[i];
      repeat (p) @(negedge clk);
    end
    rxd_b = 1'b1;
  endtask

  task automatic tx_cap(input int p, input int n, output logic [10:0] bits);
    int w;
    bits = '1;
    w = 0;
    while (txd !== 1'b0 && w < 6000) begin @(negedge clk); w++; end
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (p) @(negedge clk);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input bit len8,
                                            input bit pen, input bit pb);
    logic [10:0] f;
    int nd;
    f = '1; f[0] = 1'b0;
    nd = len8 ? 8 : 7;
    for (int i = 0; i < nd; i++) f[1 + i] = d[i];
    if (pen) f[1 + nd] = pb;
    return f;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] cap;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 txd", txd, 1); chk("R14 rts_n", rts_n, 1); chk("R14 tx_empty", tx_empty, 1);
    chk("R14 tx_busy", tx_busy, 0); chk("R14 rx_valid", rx_valid, 0);
    chk("R14 flags", {err_parity, err_frame, err_overrun, rx_break}, 0);

    // R2 divisor 0 halts both directions; R8 no handshake means rts_n high
    wr(2'd0, 16'h003C);
    chk("R8 rts_n with handshake off", rts_n, 1);
    lows = 0;
    fork
      rx_send({1'b1, 8'h81, 1'b0}, 10, 32);
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    join
    chk("R2 txd held while halted", lows, 0);
    chk("R2 no receive while halted", rx_valid, 0);

    // R1 bit period: 0x3C starts with start,0,0 -> 3 low bits = 96 clocks at D=2
    wr(2'd1, 16'd2);
    while (txd !== 1'b0) @(negedge clk);
    lows = 0;
    while (txd === 1'b0) begin lows++; @(negedge clk); end
    chk("R1 bit period 16*D", lows, 96);
    repeat (400) @(negedge clk);

    // R3/R4/R9 table walk with loopback
    loop = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [3:0] md;
      logic [7:0] dd;
      logic pen, l8;
      int nb;
      md = VEC[v][12:9]; dd = VEC[v][8:1];
      l8 = md[0]; pen = (md[2:1] == 2'b01) || (md[2:1] == 2'b10);
      nb = 2 + (l8 ? 8 : 7) + (pen ? 1 : 0);
      wr(2'd2, {12'h0, md});
      wr(2'd0, {8'h0, dd});
      tx_cap(32, nb, cap);
      chk($sformatf("R3 R4 frame vec%0d", v), cap, exp_frame(dd, l8, pen, VEC[v][0]));
      repeat (40) @(negedge clk);
      chk($sformatf("R9 valid vec%0d", v), rx_valid, 1);
      chk($sformatf("R9 data vec%0d", v), rd_data, l8 ? dd : {1'b0, dd[6:0]});
      chk($sformatf("R9 no errors vec%0d", v), {err_parity, err_frame, err_overrun}, 0);
      pop();
      chk($sformatf("R9 pop clears vec%0d", v), rx_valid, 0);
    end
    loop = 1'b0;

    // R6/R8/R5/R7 handshake
    wr(2'd2, 16'h0009);
    cts_n = 1'b1;
    wr(2'd0, 16'h005A);
    @(negedge clk);
    chk("R8 rts_n low while pending", rts_n, 0);
    lows = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R6 held while cts_n high", lows, 0);
    chk("R6 byte kept in holding register", tx_empty, 0);
    wr(2'd0, 16'h0077);
    cts_n = 1'b0;
    fork
      tx_cap(32, 10, cap);
      begin repeat (100) @(negedge clk); cts_n = 1'b1; end
    join
    chk("R7 R5 frame unaffected by cts change", cap, exp_frame(8'h5A, 1'b1, 1'b0, 1'b0));
    chk("R8 rts_n high once sent", rts_n, 1);
    cts_n = 1'b0;
    lows = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R5 second write ignored", lows, 0);

    // R9 parity error: 8 bits even, 0x96 needs parity 0, send 1
    wr(2'd2, 16'h0005);
    rx_send({1'b1, 1'b1, 8'h96, 1'b0}, 11, 32);
    repeat (10) @(negedge clk);
    chk("R9 parity error flagged", err_parity, 1);
    chk("R9 parity frame data", rd_data, 8'h96);
    pop();
    chk("R9 pop clears error", err_parity, 0);

    // R10 framing error
    wr(2'd2, 16'h0001);
    rx_send({1'b0, 8'h55, 1'b0}, 10, 32);
    repeat (10) @(negedge clk);
    chk("R10 framing error", err_frame, 1);
    chk("R10 not a break", rx_break, 0);
    chk("R10 data kept", rd_data, 8'h55);
    pop();

    // R11 break
    rx_send(11'h000, 11, 32);
    repeat (10) @(negedge clk);
    chk("R11 break flag", rx_break, 1);
    chk("R11 framing with break", err_frame, 1);
    chk("R11 break data zero", rd_data, 0);
    pop();
    repeat (100) @(negedge clk);
    chk("R11 single report for break", rx_valid, 0);

    // R12 overrun keeps first byte
    rx_send({1'b1, 8'h11, 1'b0}, 10, 32);
    repeat (20) @(negedge clk);
    rx_send({1'b1, 8'h22, 1'b0}, 10, 32);
    repeat (10) @(negedge clk);
    chk("R12 overrun flag", err_overrun, 1);
    chk("R12 old byte kept", rd_data, 8'h11);
    pop();
    chk("R12 pop clears overrun", err_overrun, 0);

    // R12 read in the completion cycle, R1 D=1
    wr(2'd1, 16'd1);
    repeat (40) @(negedge clk);
    rx_send({1'b1, 8'hC3, 1'b0}, 10, 16);
    repeat (20) @(negedge clk);
    chk("R1 receive at D=1", rd_data, 8'hC3);
    fork
      rx_send({1'b1, 8'hE7, 1'b0}, 10, 16);
      begin repeat (154) @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; end
    join
    repeat (5) @(negedge clk);
    chk("R12 same-cycle valid", rx_valid, 1);
    chk("R12 same-cycle new byte", rd_data, 8'hE7);
    chk("R12 same-cycle no overrun", err_overrun, 0);
    pop();

    // R13 rate tolerance at D=10 (nominal 160 clocks per bit)
    wr(2'd1, 16'd10);
    repeat (50) @(negedge clk);
    rx_send({1'b1, 8'hA3, 1'b0}, 10, 155);
    repeat (40) @(negedge clk);
    chk("R13 fast data", rd_data, 8'hA3);
    chk("R13 fast no error", {err_frame, err_parity}, 0);
    pop();
    rx_send({1'b1, 8'h5C, 1'b0}, 10, 164);
    repeat (40) @(negedge clk);
    chk("R13 slow data", rd_data, 8'h5C);
    chk("R13 slow valid", rx_valid, 1);
    chk("R13 slow no error", {err_frame, err_parity}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule